// File: doc/BRIEF.md
# Second-Order Bitstream Modulator for a Loop-Current DAC

This block turns a latched current code into a single-bit pulse-density stream. The stream drives a switched current source, and an external RC network averages it into a loop current. Two code formats are accepted. In the first, a 16-bit word spans the 4 mA to 20 mA band. In the second, a 17-bit word spans 0 mA to 32 mA for signalling a fault. Both formats share one LSB weight, so the block places them on a common 17-bit scale. On that scale, full scale (2^17) means 32 mA and 0x04000 means 4 mA.

The mapped value is held in a target register that changes only on a load strobe. A second-order integrator-chain loop with a one-bit quantizer runs once per enabled clock. Its two integrators carry guard bits above the code width. When the enable is low, the loop and its output freeze.

Top module: `sdm_dac_mod`

## Requirements
- R1: With `alarm_mode` low at a load, the target becomes 0x04000 plus `code[15:0]`; `code[16]` is ignored.
- R2: With `alarm_mode` high at a load, the target becomes `code` clamped to the window 0x03800 to 0x18000 inclusive.
- R3: The target changes only on a clock edge where `load` is high. Changes on `code` or `alarm_mode` without a load have no effect on the stream.
- R4: Over any 4096 consecutive enabled cycles with a constant target x, the count of ones on `bit_out` is within 4 of 4096*x/2^17, which is x/32.
- R5: While `en` is low, `bit_out` and the loop state hold their values.
- R6: A synchronous active-low reset drives `bit_out` to 0, clears both integrators and sets the target to 0x04000 (4 mA). The stream after reset therefore has density 1/8.
- R7: Neither integrator leaves the signed range of ±2^(W-2), where W is the integrator width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Loop runs when high, freezes when low |
| load | input | 1 | Capture the mapped code into the target |
| alarm_mode | input | 1 | 1: 17-bit fault scale, 0: 16-bit 4-20 mA scale |
| code | input | 17 | Current code |
| bit_out | output | 1 | Single-bit density stream |

## Verification
The assertions assume three things about the inputs. `rst_n` is low at time zero. `load` and `code` are settled before each rising edge. The target held by the loop lies inside the fault window, and the integrator bound depends on that. The stimulus changes inputs only on falling edges. It raises `load` for exactly one cycle per new code. It keeps the target constant for the whole of each counting window, so each ones count can be compared against x/32.

// File: rtl/sdm_pkg.sv
// Shared widths and scale points for the bitstream modulator.
// Assumes the two code formats share one LSB weight.
package sdm_pkg;
    localparam int CODE_W  = 17;
    localparam int NORM_W  = 16;
    localparam int GUARD_W = 6;
    localparam int INT_W   = CODE_W + GUARD_W;
    localparam logic [CODE_W-1:0] ZERO_POINT = 17'h04000;
    localparam logic [CODE_W-1:0] WIN_LO     = 17'h03800;
    localparam logic [CODE_W-1:0] WIN_HI     = 17'h18000;
endpackage

// File: rtl/sdm_code_map.sv
// Puts either code format on the common 17-bit scale.
// Normal codes are offset to the 4 mA point, and fault codes are clamped to
// the safe window. Purely combinational.
module sdm_code_map
    import sdm_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int NW = NORM_W,
    parameter logic [CW-1:0] OFFSET = ZERO_POINT,
    parameter logic [CW-1:0] LO = WIN_LO,
    parameter logic [CW-1:0] HI = WIN_HI
) (
    input  logic          alarm_mode,
    input  logic [CW-1:0] code,
    output logic [CW-1:0] mapped
);
    localparam int PAD = CW - NW;

    logic [CW-1:0] norm_val;
    logic [CW-1:0] alarm_val;

    // Offset the 16-bit word and clamp the 17-bit word, then select.
    always_comb begin
        norm_val = OFFSET + {{PAD{1'b0}}, code[NW-1:0]};
        if (code < LO)      alarm_val = LO;
        else if (code > HI) alarm_val = HI;
        else                alarm_val = code;
        mapped = alarm_mode ? alarm_val : norm_val;
    end
endmodule

// File: rtl/sdm_target_reg.sv
// Holds the mapped code that the loop converts.
// It loads only on a strobe and resets to the 4 mA point.
module sdm_target_reg
    import sdm_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter logic [CW-1:0] RST_VAL = ZERO_POINT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] din,
    output logic [CW-1:0] q
);
    // Capture on load, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= RST_VAL;
        else if (load) q <= din;
    end
endmodule

// File: rtl/sdm_loop.sv
// Second-order integrator-chain modulator with a one-bit quantizer.
// The input is re-centred around half scale. The feedback is plus or minus
// half scale. The output bit is 1 when the second integrator is at or above
// zero, which is half scale in the offset view. Assumes the input stays
// inside the fault window so that the integrators stay bounded.
module sdm_loop
    import sdm_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int GW = GUARD_W,
    localparam int IW = CW + GW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [CW-1:0]        x,
    output logic                 y,
    output logic signed [IW-1:0] int1,
    output logic signed [IW-1:0] int2
);
    localparam logic signed [IW-1:0] HALF = IW'(1) <<< (CW - 1);

    logic signed [IW-1:0] u;
    logic signed [IW-1:0] fb;
    logic signed [IW-1:0] i1_d;
    logic signed [IW-1:0] i2_d;

    // Next integrator values from the centred input and the fed-back bit.
    always_comb begin
        u    = $signed({{GW{1'b0}}, x}) - HALF;
        fb   = y ? HALF : -HALF;
        i1_d = int1 + u - fb;
        i2_d = int2 + i1_d - fb;
    end

    // State update on enabled cycles only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int1 <= '0;
            int2 <= '0;
            y    <= 1'b0;
        end else if (en) begin
            int1 <= i1_d;
            int2 <= i2_d;
            y    <= ~i2_d[IW-1];
        end
    end
endmodule

// File: rtl/sdm_dac_mod.sv
// Top of the bitstream modulator: code mapping, target register, loop.
// Assumes inputs are synchronous to clk.
module sdm_dac_mod
    import sdm_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int GW = GUARD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          load,
    input  logic          alarm_mode,
    input  logic [CW-1:0] code,
    output logic          bit_out
);
    localparam int IW = CW + GW;

    logic [CW-1:0]        mapped;
    logic [CW-1:0]        target;
    logic signed [IW-1:0] int1;
    logic signed [IW-1:0] int2;

    sdm_code_map #(.CW(CW)) u_map (
        .alarm_mode(alarm_mode),
        .code      (code),
        .mapped    (mapped)
    );

    sdm_target_reg #(.CW(CW)) u_tgt (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .din  (mapped),
        .q    (target)
    );

    sdm_loop #(.CW(CW), .GW(GW)) u_loop (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .x    (target),
        .y    (bit_out),
        .int1 (int1),
        .int2 (int2)
    );
endmodule

// File: rtl/sdm_dac_mod_chk.sv
// Property checker for sdm_dac_mod, attached by bind.
module sdm_dac_mod_chk
    import sdm_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int IW = INT_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 en,
    input logic                 load,
    input logic                 alarm_mode,
    input logic [CW-1:0]        code,
    input logic                 bit_out,
    input logic [CW-1:0]        target,
    input logic signed [IW-1:0] int1,
    input logic signed [IW-1:0] int2
);
    localparam logic signed [IW-1:0] LIM = IW'(1) <<< (IW - 2);

    a_r1_normal_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !alarm_mode) |=> target == ZERO_POINT + {1'b0, $past(code[15:0])});

    a_r2_target_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (target >= WIN_LO) && (target <= WIN_HI));

    a_r3_target_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(target));

    a_r5_frozen_output: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(bit_out) && $stable(int1) && $stable(int2));

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (int1 < LIM) && (int1 >= -LIM) && (int2 < LIM) && (int2 >= -LIM));
endmodule

bind sdm_dac_mod sdm_dac_mod_chk #(.CW(CW), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .load      (load),
    .alarm_mode(alarm_mode),
    .code      (code),
    .bit_out   (bit_out),
    .target    (target),
    .int1      (int1),
    .int2      (int2)
);

// File: tb/sdm_dac_mod_tb.sv
module sdm_dac_mod_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WIN = 4096;
    localparam int TOL = 4;
    localparam int NVEC = 8;
    // {alarm_mode, code, expected target}
    localparam logic [34:0] VECS [NVEC] = '{
        {1'b0, 17'h00000, 17'h04000},
        {1'b0, 17'h0FFFF, 17'h13FFF},
        {1'b0, 17'h18000, 17'h0C000},
        {1'b0, 17'h01234, 17'h05234},
        {1'b1, 17'h03C00, 17'h03C00},
        {1'b1, 17'h00000, 17'h03800},
        {1'b1, 17'h1FFFF, 17'h18000},
        {1'b1, 17'h10000, 17'h10000}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic en = 0;
    logic load = 0;
    logic alarm_mode = 0;
    logic [16:0] code = '0;
    logic bit_out;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdm_dac_mod u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .load(load),
        .alarm_mode(alarm_mode), .code(code), .bit_out(bit_out)
    );

    task automatic check_int(input string req, input int act, input int exp, input int tol);
        int d;
        total++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_load(input logic m, input logic [16:0] c);
        @(negedge clk);
        alarm_mode = m;
        code = c;
        load = 1;
        @(negedge clk);
        load = 0;
    endtask

    task automatic measure(output int ones);
        ones = 0;
        repeat (8) @(negedge clk);
        for (int k = 0; k < WIN; k++) begin
            @(negedge clk);
            ones += int'(bit_out);
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 200000) @(negedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int ones;
        int held;
        int same;
        repeat (3) @(negedge clk);
        // R6: reset output state
        check_int("R6", int'(bit_out), 0, 0);
        rst_n = 1;
        en = 1;
        // R6: default target is 4 mA, density 1/8
        measure(ones);
        check_int("R6", ones, 17'h04000 / 32, TOL);

        // R1, R2, R4: table of codes and densities
        for (int i = 0; i < NVEC; i++) begin
            do_load(VECS[i][34], VECS[i][33:17]);
            measure(ones);
            check_int(VECS[i][34] ? "R2/R4" : "R1/R4", ones, int'(VECS[i][16:0]) / 32, TOL);
        end

        // R3: input changes without load leave the stream unchanged
        do_load(1'b1, 17'h10000);
        @(negedge clk);
        alarm_mode = 0;
        code = 17'h00000;
        measure(ones);
        check_int("R3", ones, 17'h10000 / 32, TOL);

        // R5: output holds while disabled
        @(negedge clk);
        en = 0;
        held = int'(bit_out);
        same = 1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (int'(bit_out) != held) same = 0;
        end
        check_int("R5", same, 1, 0);
        // R5: a load while disabled takes effect, loop resumes on enable
        do_load(1'b1, 17'h0C000);
        en = 1;
        measure(ones);
        check_int("R5/R4", ones, 17'h0C000 / 32, TOL);

        // R6: reset mid-run restores 4 mA target and zero output
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        check_int("R6", int'(bit_out), 0, 0);
        rst_n = 1;
        measure(ones);
        check_int("R6", ones, 17'h04000 / 32, TOL);

        // R4 boundary: window edges hold density
        do_load(1'b1, 17'h03800);
        measure(ones);
        check_int("R4", ones, 17'h03800 / 32, TOL);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule